// File: doc/BRIEF.md
# Paged Digital Port Register Bank

This block is a byte-wide register slave that sits between a host access port and six 8-bit open-drain style I/O ports. Each port has an output latch whose set bits turn on a pad's current sink, pulling the line low; a cleared bit releases the line so an outside pull-up lifts it and the pin can be used as an input. Reading a port returns the inverse of the synchronized pad level. Because of this, a pin that the block is driving low reads back as 1, and an undriven pin that is pulled high reads as 0.

One register at offset 0x07 does two jobs. Its top two bits pick a page, and its six low bits are write locks, one per port. Offsets 0x08 to 0x0A form a window whose meaning depends on the selected page. On pages 1 to 3 an access to that window is handed to a separate interrupt unit through a select, a write strobe, the page, a register index and the write data. The interrupt unit returns a read value, and the block captures it as the host read data. Offset 0x06 returns the pending summary that the interrupt unit supplies for the three interrupt-capable ports. The synchronized levels of ports 0 to 2 are also passed on to that unit.

Top module: `pdio_regbank`

## Requirements
- R1: A synchronous reset clears every output latch so all pins are released, clears all lock bits, selects page 0, clears the read data register and clears the pad synchronizers.
- R2: A host write to offset k (0 to 5) loads port k's latch on that clock edge when port k is unlocked. Latch bit j drives sink_en[8k+j], where 1 means sink (pin low) and 0 means released.
- R3: A host read of offset k (0 to 5) returns the bitwise inverse of port k's pad levels as seen through a two-flop synchronizer. The value is registered and appears on host_rdata one clock after the read strobe.
- R4: Offset 0x07 reads back as {page[1:0] in bits 7:6, lock[5:0] in bits 5:0}.
- R5: While lock bit k (bit k of offset 0x07) is 1, writes to port k leave its latch unchanged. Other ports can still be written.
- R6: Offset 0x07 can always be written, whatever the lock bits hold, so locks can be released and the page changed at any time.
- R7: With page 1, 2 or 3 selected, a read or write of offsets 0x08 to 0x0A drives iu_sel high, iu_page with the page, iu_idx with offset minus 8, and iu_wdata with the host data. iu_we follows the host write. A read of these offsets returns iu_rdata one clock later.
- R8: With page 0 selected, offsets 0x08 to 0x0A raise neither iu_sel nor iu_we, read as 0x00, and writes to them change no latch.
- R9: Offset 0x06 reads as {5'b0, iu_pend[2:0]}. Writes to it change nothing.
- R10: Offsets 0x0B to 0x0F read as 0x00, and writes to them change nothing.
- R11: iu_pins carries the synchronized pad levels of ports 0 to 2 (pad bits 23:0), two clocks after the pads.
- R12: host_rdata holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Registered read data |
| pad_in | input | 48 | Pad levels, port k on bits 8k+7:8k |
| sink_en | output | 48 | Sink enables, 1 pulls the pin low |
| iu_sel | output | 1 | Banked window access to the interrupt unit |
| iu_we | output | 1 | Write strobe to the interrupt unit |
| iu_page | output | 2 | Selected page for the banked access |
| iu_idx | output | 2 | Banked register index (port 0 to 2) |
| iu_wdata | output | 8 | Write data to the interrupt unit |
| iu_rdata | input | 8 | Read value from the interrupt unit |
| iu_pend | input | 3 | Pending summary for ports 0 to 2 |
| iu_pins | output | 24 | Synchronized levels of ports 0 to 2 |

## Verification
The case that is hardest to reach from the ports is a write that arrives while its port is locked. Only a locked write can show that the lock is checked against the stored bits and not against the data of the same access. The stimulus first writes a lock pattern, then tries to write the locked port and one unlocked port, and reads the result back. It then sets every lock bit and writes offset 0x07 again, which shows that the lock register cannot lock itself. Readback of a driven pin needs the pad model to combine the bench's external level with the block's own sink enables, so the inverted read reflects both. A random phase then mixes page changes with banked and port accesses, and a cycle-level model checks every output on every clock.

// File: rtl/pdio_pkg.sv
package pdio_pkg;
  localparam int DATA_W        = 8;
  localparam int NUM_PORTS     = 6;
  localparam int NUM_IRQ_PORTS = 3;
  localparam int ADDR_W        = 4;
  localparam int PAGE_W        = 2;
  localparam int IDX_W         = $clog2(NUM_IRQ_PORTS);

  typedef enum logic [PAGE_W-1:0] {
    PAGE_NONE = 2'd0,
    PAGE_POL  = 2'd1,
    PAGE_ENA  = 2'd2,
    PAGE_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/pdio_sync.sv
module pdio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pdio_decode.sv
module pdio_decode #(
  parameter int ADDR_W        = 4,
  parameter int NUM_PORTS     = 6,
  parameter int NUM_IRQ_PORTS = 3,
  parameter int IDX_W         = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic                 pend_hit,
  output logic                 pglk_hit,
  output logic                 bank_hit,
  output logic [IDX_W-1:0]     bank_idx
);
  localparam int OFF_PEND = NUM_PORTS;
  localparam int OFF_PGLK = NUM_PORTS + 1;
  localparam int OFF_BANK = NUM_PORTS + 2;
  localparam int OFF_END  = OFF_BANK + NUM_IRQ_PORTS;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_hit
    assign port_hit[k] = (addr == ADDR_W'(k));
  end

  assign pend_hit = (addr == ADDR_W'(OFF_PEND));
  assign pglk_hit = (addr == ADDR_W'(OFF_PGLK));
  assign bank_hit = (addr >= ADDR_W'(OFF_BANK)) && (addr < ADDR_W'(OFF_END));
  assign bank_idx = IDX_W'(addr - ADDR_W'(OFF_BANK));
endmodule

// File: rtl/pdio_port.sv
module pdio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/pdio_regbank.sv
module pdio_regbank
  import pdio_pkg::*;
#(
  parameter int DATA_W        = pdio_pkg::DATA_W,
  parameter int NUM_PORTS     = pdio_pkg::NUM_PORTS,
  parameter int NUM_IRQ_PORTS = pdio_pkg::NUM_IRQ_PORTS,
  parameter int ADDR_W        = pdio_pkg::ADDR_W,
  parameter int PAGE_W        = pdio_pkg::PAGE_W,
  parameter int IDX_W         = pdio_pkg::IDX_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [DATA_W-1:0]             host_wdata,
  input  logic                          host_wr,
  input  logic                          host_rd,
  output logic [DATA_W-1:0]             host_rdata,
  input  logic [NUM_PORTS*DATA_W-1:0]   pad_in,
  output logic [NUM_PORTS*DATA_W-1:0]   sink_en,
  output logic                          iu_sel,
  output logic                          iu_we,
  output logic [PAGE_W-1:0]             iu_page,
  output logic [IDX_W-1:0]              iu_idx,
  output logic [DATA_W-1:0]             iu_wdata,
  input  logic [DATA_W-1:0]             iu_rdata,
  input  logic [NUM_IRQ_PORTS-1:0]      iu_pend,
  output logic [NUM_IRQ_PORTS*DATA_W-1:0] iu_pins
);
  localparam int PADS_W = NUM_PORTS * DATA_W;
  localparam int IRQ_W  = NUM_IRQ_PORTS * DATA_W;

  logic [PADS_W-1:0]    pad_sync;
  logic [NUM_PORTS-1:0] port_hit;
  logic                 pend_hit;
  logic                 pglk_hit;
  logic                 bank_hit;
  logic [IDX_W-1:0]     bank_idx;
  logic [NUM_PORTS-1:0] lock_q;
  page_e                page_q;
  logic [DATA_W-1:0]    rd_mux;
  logic                 bank_live;

  pdio_sync #(.W(PADS_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  pdio_decode #(
    .ADDR_W        (ADDR_W),
    .NUM_PORTS     (NUM_PORTS),
    .NUM_IRQ_PORTS (NUM_IRQ_PORTS),
    .IDX_W         (IDX_W)
  ) u_dec (
    .addr     (host_addr),
    .port_hit (port_hit),
    .pend_hit (pend_hit),
    .pglk_hit (pglk_hit),
    .bank_hit (bank_hit),
    .bank_idx (bank_idx)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    pdio_port #(.W(DATA_W)) u_port (
      .clk   (clk),
      .rst   (rst),
      .we    (host_wr && port_hit[k] && !lock_q[k]),
      .wdata (host_wdata),
      .q     (sink_en[k*DATA_W +: DATA_W])
    );
  end

  // page select and lock bits share one register that no lock can block
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= PAGE_NONE;
      lock_q <= '0;
    end else if (host_wr && pglk_hit) begin
      page_q <= page_e'(host_wdata[DATA_W-1 -: PAGE_W]);
      lock_q <= host_wdata[NUM_PORTS-1:0];
    end
  end

  // forwarding into the interrupt unit for the banked window
  assign bank_live = bank_hit && (page_q != PAGE_NONE);
  assign iu_sel    = bank_live && (host_rd || host_wr);
  assign iu_we     = bank_live && host_wr;
  assign iu_page   = page_q;
  assign iu_idx    = bank_idx;
  assign iu_wdata  = host_wdata;
  assign iu_pins   = pad_sync[IRQ_W-1:0];

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (port_hit[k]) rd_mux = ~pad_sync[k*DATA_W +: DATA_W];
    end
    if (pend_hit) rd_mux[NUM_IRQ_PORTS-1:0] = iu_pend;
    if (pglk_hit) begin
      rd_mux[DATA_W-1 -: PAGE_W]  = page_q;
      rd_mux[NUM_PORTS-1:0]       = lock_q;
    end
    if (bank_live) rd_mux = iu_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end
endmodule

// File: rtl/pdio_regbank_chk.sv
module pdio_regbank_chk #(
  parameter int DATA_W        = 8,
  parameter int NUM_PORTS     = 6,
  parameter int NUM_IRQ_PORTS = 3,
  parameter int ADDR_W        = 4,
  parameter int PAGE_W        = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           host_addr,
  input logic [DATA_W-1:0]           host_wdata,
  input logic                        host_wr,
  input logic                        host_rd,
  input logic [DATA_W-1:0]           host_rdata,
  input logic [NUM_PORTS*DATA_W-1:0] sink_en,
  input logic                        iu_sel,
  input logic                        iu_we,
  input logic [NUM_PORTS-1:0]        lock_bits,
  input logic [PAGE_W-1:0]           page_sel
);
  localparam int OFF_PGLK = NUM_PORTS + 1;
  localparam int OFF_LAST = NUM_PORTS + 1 + NUM_IRQ_PORTS;

  logic seen_rst;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    (seen_rst && $past(rst)) |->
      (sink_en == '0 && host_rdata == '0 && lock_bits == '0 && page_sel == '0));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
    a_r2_port_write: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_addr == ADDR_W'(k) && !lock_bits[k]) |=>
        (sink_en[k*DATA_W +: DATA_W] == $past(host_wdata)));
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_addr == ADDR_W'(k) && lock_bits[k]) |=> $stable(sink_en));
  end

  a_r6_pglk_write: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == ADDR_W'(OFF_PGLK)) |=>
      (lock_bits == $past(host_wdata[NUM_PORTS-1:0])));

  a_r7_we_with_sel: assert property (@(posedge clk) disable iff (rst)
    iu_we |-> (iu_sel && host_wr));

  a_r8_page0_quiet: assert property (@(posedge clk) disable iff (rst)
    (page_sel == '0) |-> !iu_sel);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr > ADDR_W'(OFF_LAST)) |=> (host_rdata == '0));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind pdio_regbank pdio_regbank_chk #(
  .DATA_W        (DATA_W),
  .NUM_PORTS     (NUM_PORTS),
  .NUM_IRQ_PORTS (NUM_IRQ_PORTS),
  .ADDR_W        (ADDR_W),
  .PAGE_W        (PAGE_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .sink_en    (sink_en),
  .iu_sel     (iu_sel),
  .iu_we      (iu_we),
  .lock_bits  (lock_q),
  .page_sel   (page_q)
);

// File: tb/pdio_regbank_tb_top.sv
module pdio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic [47:0] ext = '1;
  logic [47:0] pad_in;
  logic [47:0] sink_en;
  logic        iu_sel, iu_we;
  logic [1:0]  iu_page, iu_idx;
  logic [7:0]  iu_wdata, iu_rdata;
  logic [2:0]  iu_pend = '0;
  logic [23:0] iu_pins;

  int  checks = 0;
  int  errors = 0;
  bit  armed = 1'b0;

  always #5 clk = ~clk;

  assign pad_in   = ext & ~sink_en;
  assign iu_rdata = {iu_page, 3'b101, iu_idx, 1'b1};

  pdio_regbank dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .pad_in(pad_in), .sink_en(sink_en), .iu_sel(iu_sel), .iu_we(iu_we),
    .iu_page(iu_page), .iu_idx(iu_idx), .iu_wdata(iu_wdata),
    .iu_rdata(iu_rdata), .iu_pend(iu_pend), .iu_pins(iu_pins)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [47:0] msink = '0, ps1 = '0, ps2 = '0;
  logic [5:0]  mlock = '0;
  logic [1:0]  mpage = '0;
  logic [7:0]  mrdata = '0;

  function automatic logic [7:0] bank_val(logic [1:0] p, logic [1:0] i);
    return {p, 3'b101, i, 1'b1};
  endfunction

  function automatic logic [7:0] model_read(logic [3:0] a);
    if (a < 4'd6)  return ~ps2[a*8 +: 8];
    if (a == 4'd6) return {5'b0, iu_pend};
    if (a == 4'd7) return {mpage, mlock};
    if (a >= 4'd8 && a <= 4'd10) return (mpage == 2'd0) ? 8'h00 : bank_val(mpage, 2'(a - 4'd8));
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    logic [47:0] padv;
    if (rst) begin
      msink = '0; ps1 = '0; ps2 = '0; mlock = '0; mpage = '0; mrdata = '0;
      armed = 1'b1;
    end else begin
      padv = ext & ~msink;
      if (host_rd) mrdata = model_read(host_addr);
      if (host_wr) begin
        if (host_addr < 4'd6 && !mlock[host_addr]) msink[host_addr*8 +: 8] = host_wdata;
        else if (host_addr == 4'd7) begin
          mpage = host_wdata[7:6];
          mlock = host_wdata[5:0];
        end
      end
      ps2 = ps1;
      ps1 = padv;
    end
  end

  always @(negedge clk) begin
    logic expsel;
    if (armed) begin
      chk("R2 sink_en model", sink_en, msink);
      chk("R3 host_rdata model", host_rdata, mrdata);
      chk("R11 iu_pins model", iu_pins, ps2[23:0]);
      expsel = (host_rd || host_wr) && host_addr >= 4'd8 && host_addr <= 4'd10 && mpage != 2'd0;
      chk("R7 iu_sel model", iu_sel, expsel);
      chk("R8 iu_we model", iu_we, expsel && host_wr);
      if (expsel)
        chk("R7 iu fields model", {iu_page, iu_idx, iu_wdata},
            {mpage, 2'(host_addr - 4'd8), host_wdata});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #2;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    host_addr = a; host_rd = 1'b1;
    @(posedge clk); #2;
    host_rd = 1'b0;
    @(negedge clk);
    chk(tag, host_rdata, e);
  endtask

  task automatic wr_probe(input logic [3:0] a, input logic [7:0] d,
                          input logic es, input logic [1:0] ep, input logic [1:0] ei,
                          input string tag);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #1;
    chk(tag, {iu_sel, iu_we}, {es, es});
    if (es) chk(tag, {iu_page, iu_idx, iu_wdata}, {ep, ei, d});
    @(posedge clk); #2;
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1 sink_en after reset", sink_en, 48'h0);
    chk("R1 rdata after reset", host_rdata, 8'h00);
    chk("R1 iu_pins after reset", iu_pins, 24'h0);
    rd(4'd7, 8'h00, "R1 page/lock after reset");

    // inverted readback of pad levels
    ext = 48'hA5_3C_F0_0F_69_96;
    repeat (3) @(posedge clk);
    rd(4'd0, 8'h69, "R3 port0 inverted");
    rd(4'd5, 8'h5A, "R3 port5 inverted");
    @(negedge clk);
    chk("R11 iu_pins pass", iu_pins, 24'h0F6996);

    // sink control and readback of a driven pin
    wr(4'd3, 8'h81);
    @(negedge clk);
    chk("R2 port3 sink", sink_en[31:24], 8'h81);
    repeat (3) @(posedge clk);
    rd(4'd3, 8'h8F, "R3 port3 readback");
    wr(4'd3, 8'h00);
    @(negedge clk);
    chk("R2 port3 released", sink_en[31:24], 8'h00);

    // locks
    wr(4'd7, 8'h02);
    rd(4'd7, 8'h02, "R4 page/lock readback");
    wr(4'd1, 8'hFF);
    @(negedge clk);
    chk("R5 locked port1 unchanged", sink_en[15:8], 8'h00);
    wr(4'd0, 8'h11);
    @(negedge clk);
    chk("R5 unlocked port0 written", sink_en[7:0], 8'h11);
    wr(4'd7, 8'h00);
    wr(4'd1, 8'h22);
    @(negedge clk);
    chk("R6 port1 after unlock", sink_en[15:8], 8'h22);
    wr(4'd7, 8'h3F);
    wr(4'd7, 8'h40);
    rd(4'd7, 8'h40, "R6 page/lock rewritable when all locked");

    // banked window
    rd(4'd9, bank_val(2'd1, 2'd1), "R7 page1 idx1 read");
    wr_probe(4'd10, 8'h33, 1'b1, 2'd1, 2'd2, "R7 page1 idx2 write");
    wr(4'd7, 8'hC0);
    rd(4'd8, bank_val(2'd3, 2'd0), "R7 page3 idx0 read");
    wr(4'd7, 8'h00);
    rd(4'd8, 8'h00, "R8 page0 bank read");
    wr_probe(4'd8, 8'hEE, 1'b0, 2'd0, 2'd0, "R8 page0 no forward");
    @(negedge clk);
    chk("R8 latches unchanged", sink_en, 48'h0000_0000_2211);

    // pending summary
    iu_pend = 3'b101;
    rd(4'd6, 8'h05, "R9 pending summary");
    wr(4'd6, 8'hFF);
    @(negedge clk);
    chk("R9 write ignored", sink_en, 48'h0000_0000_2211);
    rd(4'd6, 8'h05, "R9 pending after write");

    // unmapped offsets
    rd(4'd12, 8'h00, "R10 unmapped read");
    wr(4'd15, 8'hFF);
    @(negedge clk);
    chk("R10 unmapped write ignored", sink_en, 48'h0000_0000_2211);
    rd(4'd15, 8'h00, "R10 offset 0x0F read");

    // read data holds without strobe
    rd(4'd0, ~((ext[7:0]) & ~8'h11), "R12 read port0");
    ext = 48'h0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12 rdata held", host_rdata, ~((48'hA5_3C_F0_0F_69_96 >> 0) & ~48'h11) & 48'hFF);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #2;
      host_addr  = 4'($urandom);
      host_wdata = 8'($urandom);
      host_rd    = 1'($urandom);
      host_wr    = ($urandom % 3 == 0);
      iu_pend    = 3'($urandom);
      if (i % 29 == 0) ext = 48'({$urandom, $urandom});
    end
    @(posedge clk); #2;
    host_rd = 1'b0; host_wr = 1'b0;
    repeat (3) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule